// File: doc/BRIEF.md
# Multi-Domain Scan Chain with Polarity-Aware Lockups

This block is a set of identical scan chains. Each chain is a series of segments, and each segment runs on its own shift clock domain. A segment is built from rising-edge flops or from falling-edge flops. At every joint between two segments, generate logic inserts a hold-protection element. The element is chosen from the edge polarities of the launching segment and the capturing segment, so shifting stays correct even when the capture clock arrives later than the launch clock. Every lockup latch and every dummy flop is clocked by the launching segment's clock.

When scan enable is high, every functional flop takes the value of the element before it in the chain. When scan enable is low, every functional flop loads its own functional data bit. Lockup latches and dummy flops never load functional data. Each chain ends in a tail lockup, chosen by the same polarity rule for the pair (last segment, first segment). The tail drives that chain's scan output. When the burn-in select is high, all chains are joined into one long chain: chain c+1 takes its scan input from the tail of chain c.

The shift clocks are return-to-zero: each one rests low and pulses high. The segment count, the length of each segment and the polarity of each segment are set at elaboration time.

Top module: `xdom_scan_top`

## Requirements
- R1: While rst_n is low, every flop and latch in the block is cleared, so func_q and scan_out read all zeros.
- R2: While scan_en is high, each functional flop loads its chain predecessor on its own active edge: the rising edge for a segment whose SEG_NEG bit is 0, and the falling edge for a segment whose SEG_NEG bit is 1. Flop 0 of chain c is the flop nearest the scan input.
- R3: A joint from a rising-edge segment to a rising-edge segment holds a latch that is clocked by the launching clock and is open while that clock is low.
- R4: A joint from a falling-edge segment to a falling-edge segment holds a latch that is clocked by the launching clock and is open while that clock is high.
- R5: A joint from a falling-edge segment to a rising-edge segment is a direct wire with no lockup element.
- R6: A joint from a rising-edge segment to a falling-edge segment holds a rising-edge dummy flop clocked by the launching clock. The dummy flop is not part of func_q and never loads functional data.
- R7: Take a cycle to begin at a rising edge of shift_clk[0]. If scan_in[c] carries a bit during cycle k, and shifting runs with every domain's skew below half a period, that bit appears on scan_out[c] in cycle k+N. N is the number of functional flops in one chain (11 with the default parameters). Dummy flops do not add to N: they restore the cycle that a rising-to-falling joint would otherwise lose.
- R8: While scan_en is low, each functional flop loads func_d at its active edge. Bit c*N+i of func_d and of func_q belongs to flop i of chain c.
- R9: Each chain ends in a tail lockup, chosen by the rule in R3 to R6 for the pair (last segment polarity, first segment polarity). scan_out[c] is the output of that tail lockup.
- R10: While burnin_en is high, chain c+1 takes its scan input from the tail of chain c, and scan_in[c] for every c>0 has no effect. A bit entering scan_in[0] in cycle k appears on scan_out[NUM_CHAINS-1] in cycle k+NUM_CHAINS*N.
- R11: While burnin_en is low, chain c takes its scan input from scan_in[c], and the chains are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | NUM_SEGS | One shift clock per segment domain, return-to-zero |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift along the chain, 0 = load functional data |
| burnin_en | input | 1 | 1 = join all chains into one chain |
| scan_in | input | NUM_CHAINS | Serial input of each chain |
| func_d | input | NUM_CHAINS*N | Functional data, bit c*N+i goes to flop i of chain c |
| func_q | output | NUM_CHAINS*N | Contents of the functional flops |
| scan_out | output | NUM_CHAINS | Tail lockup output of each chain |

## Verification
Inputs change 4 ns after a reference rising edge, so each input value holds across both edges of the following cycle. Outputs are sampled 1.5 ns after the reference rising edge, which is later than the most-skewed rising edge and earlier than any falling edge. At that sample point, a rising-edge flop already shows the value it loaded in the current cycle, while a falling-edge flop shows the value it loaded in the previous cycle. The tail output always shows the last functional flop's value from the previous cycle. The bench runs a cycle-level model of the functional flops and compares each sample against the model's current cycle or previous cycle according to these rules. From these, a serial bit reaches scan_out N cycles after it enters, or NUM_CHAINS*N cycles in burn-in mode.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int LEN_BITS = 4;
    localparam int MAX_SEGS = 16;

    typedef enum logic [1:0] {
        LK_NONE       = 2'd0,
        LK_LATCH_LOW  = 2'd1,
        LK_LATCH_HIGH = 2'd2,
        LK_DUMMY      = 2'd3
    } lockup_e;

    // Pick the hold-protection element for a joint, from the launch and
    // capture edge polarities (1 = falling edge).
    function automatic lockup_e lockup_for(input logic launch_neg, input logic capture_neg);
        lockup_e kind;
        unique case ({launch_neg, capture_neg})
            2'b00:   kind = LK_LATCH_LOW;
            2'b11:   kind = LK_LATCH_HIGH;
            2'b10:   kind = LK_NONE;
            default: kind = LK_DUMMY;
        endcase
        return kind;
    endfunction

    function automatic int seg_len(input logic [MAX_SEGS*LEN_BITS-1:0] lens, input int s);
        return int'(lens[s*LEN_BITS +: LEN_BITS]);
    endfunction

    function automatic int seg_off(input logic [MAX_SEGS*LEN_BITS-1:0] lens, input int s);
        int acc = 0;
        for (int i = 0; i < s; i++) acc += seg_len(lens, i);
        return acc;
    endfunction

endpackage

// File: rtl/scan_seg.sv
module scan_seg #(
    parameter int LEN = 4,
    parameter bit NEG = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_en,
    input  logic           scan_d,
    input  logic [LEN-1:0] func_d,
    output logic [LEN-1:0] q
);

    logic [LEN-1:0] nxt;

    generate
        if (LEN == 1) begin : g_one
            always_comb nxt = scan_en ? scan_d : func_d;
        end else begin : g_many
            always_comb nxt = scan_en ? {q[LEN-2:0], scan_d} : func_d;
        end

        if (NEG) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end
            AST_SEG_SHIFT_FALL: assert property (@(negedge clk) disable iff (!rst_n)
                scan_en |=> q[0] == $past(scan_d)); // R2
            AST_SEG_CAPTURE_FALL: assert property (@(negedge clk) disable iff (!rst_n)
                !scan_en |=> q == $past(func_d)); // R8
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end
            AST_SEG_SHIFT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                scan_en |=> q[0] == $past(scan_d)); // R2
            AST_SEG_CAPTURE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                !scan_en |=> q == $past(func_d)); // R8
        end
    endgenerate

endmodule

// File: rtl/scan_lockup.sv
module scan_lockup
    import scan_pkg::*;
#(
    parameter lockup_e KIND = LK_NONE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (KIND == LK_LATCH_LOW) begin : g_latch_low
            always_latch begin
                if (!rst_n)    q <= 1'b0;
                else if (!clk) q <= d;
            end
            // Latch must have tracked its input during the low phase.
            AST_LATCH_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                q == d); // R3
        end else if (KIND == LK_LATCH_HIGH) begin : g_latch_high
            always_latch begin
                if (!rst_n)   q <= 1'b0;
                else if (clk) q <= d;
            end
            AST_LATCH_HIGH_PASS: assert property (@(negedge clk) disable iff (!rst_n)
                q == d); // R4
        end else if (KIND == LK_DUMMY) begin : g_dummy
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= d;
            end
            AST_DUMMY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> q == $past(d)); // R6
        end else begin : g_wire
            logic unused_lk;
            assign unused_lk = clk ^ rst_n;
            assign q = d; // R5: direct joint
        end
    endgenerate

endmodule

// File: rtl/scan_chain.sv
module scan_chain
    import scan_pkg::*;
#(
    parameter int                        NUM_SEGS = 4,
    parameter logic [NUM_SEGS*LEN_BITS-1:0] SEG_LENS = 16'h2423,
    parameter logic [NUM_SEGS-1:0]       SEG_NEG  = 4'b1100,
    localparam int FLOPS = seg_off((MAX_SEGS*LEN_BITS)'(SEG_LENS), NUM_SEGS)
) (
    input  logic [NUM_SEGS-1:0] clk,
    input  logic                rst_n,
    input  logic                scan_en,
    input  logic                scan_d,
    input  logic [FLOPS-1:0]    func_d,
    output logic [FLOPS-1:0]    func_q,
    output logic                tail_q
);

    localparam logic [MAX_SEGS*LEN_BITS-1:0] LENS_X = (MAX_SEGS*LEN_BITS)'(SEG_LENS);

    logic [NUM_SEGS-1:0] seg_si;
    logic [NUM_SEGS-1:0] seg_so;

    assign seg_si[0] = scan_d;

    generate
        for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
            localparam int OFF = seg_off(LENS_X, s);
            localparam int LEN = seg_len(LENS_X, s);

            scan_seg #(.LEN(LEN), .NEG(SEG_NEG[s])) u_seg (
                .clk    (clk[s]),
                .rst_n  (rst_n),
                .scan_en(scan_en),
                .scan_d (seg_si[s]),
                .func_d (func_d[OFF +: LEN]),
                .q      (func_q[OFF +: LEN])
            );
            assign seg_so[s] = func_q[OFF+LEN-1];

            if (s > 0) begin : g_link
                scan_lockup #(.KIND(lockup_for(SEG_NEG[s-1], SEG_NEG[s]))) u_lk (
                    .clk  (clk[s-1]),
                    .rst_n(rst_n),
                    .d    (seg_so[s-1]),
                    .q    (seg_si[s])
                );
            end
        end
    endgenerate

    scan_lockup #(.KIND(lockup_for(SEG_NEG[NUM_SEGS-1], SEG_NEG[0]))) u_tail (
        .clk  (clk[NUM_SEGS-1]),
        .rst_n(rst_n),
        .d    (seg_so[NUM_SEGS-1]),
        .q    (tail_q)
    );

endmodule

// File: rtl/xdom_scan_top.sv
module xdom_scan_top
    import scan_pkg::*;
#(
    parameter int                           NUM_CHAINS = 2,
    parameter int                           NUM_SEGS   = 4,
    parameter logic [NUM_SEGS*LEN_BITS-1:0] SEG_LENS   = 16'h2423,
    parameter logic [NUM_SEGS-1:0]          SEG_NEG    = 4'b1100,
    localparam int CHAIN_FLOPS = seg_off((MAX_SEGS*LEN_BITS)'(SEG_LENS), NUM_SEGS),
    localparam int TOTAL_FLOPS = NUM_CHAINS * CHAIN_FLOPS
) (
    input  logic [NUM_SEGS-1:0]    shift_clk,
    input  logic                   rst_n,
    input  logic                   scan_en,
    input  logic                   burnin_en,
    input  logic [NUM_CHAINS-1:0]  scan_in,
    input  logic [TOTAL_FLOPS-1:0] func_d,
    output logic [TOTAL_FLOPS-1:0] func_q,
    output logic [NUM_CHAINS-1:0]  scan_out
);

    logic [NUM_CHAINS-1:0] chain_si;

    generate
        for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
            if (c == 0) begin : g_head
                assign chain_si[c] = scan_in[c];
            end else begin : g_join
                assign chain_si[c] = burnin_en ? scan_out[c-1] : scan_in[c];

                if (SEG_NEG[0]) begin : g_chk_fall
                    AST_JOIN_FEED: assert property (@(negedge shift_clk[0]) disable iff (!rst_n)
                        (scan_en && burnin_en) |=> func_q[c*CHAIN_FLOPS] == $past(scan_out[c-1])); // R10
                    AST_SPLIT_FEED: assert property (@(negedge shift_clk[0]) disable iff (!rst_n)
                        (scan_en && !burnin_en) |=> func_q[c*CHAIN_FLOPS] == $past(scan_in[c])); // R11
                end else begin : g_chk_rise
                    AST_JOIN_FEED: assert property (@(posedge shift_clk[0]) disable iff (!rst_n)
                        (scan_en && burnin_en) |=> func_q[c*CHAIN_FLOPS] == $past(scan_out[c-1])); // R10
                    AST_SPLIT_FEED: assert property (@(posedge shift_clk[0]) disable iff (!rst_n)
                        (scan_en && !burnin_en) |=> func_q[c*CHAIN_FLOPS] == $past(scan_in[c])); // R11
                end
            end

            scan_chain #(
                .NUM_SEGS(NUM_SEGS),
                .SEG_LENS(SEG_LENS),
                .SEG_NEG (SEG_NEG)
            ) u_chain (
                .clk    (shift_clk),
                .rst_n  (rst_n),
                .scan_en(scan_en),
                .scan_d (chain_si[c]),
                .func_d (func_d[c*CHAIN_FLOPS +: CHAIN_FLOPS]),
                .func_q (func_q[c*CHAIN_FLOPS +: CHAIN_FLOPS]),
                .tail_q (scan_out[c])
            );
        end
    endgenerate

endmodule

// File: tb/tb_xdom_scan_top.sv
`timescale 1ns/10ps
module tb_xdom_scan_top;

    localparam int          NCH  = 2;
    localparam int          NSEG = 4;
    localparam logic [15:0] LENS = 16'h2423;   // segment lengths 3,2,4,2
    localparam logic [3:0]  NEGS = 4'b1100;    // segments 2 and 3 falling-edge
    localparam int          CF   = 11;
    localparam int          TOT  = NCH * CF;
    localparam real         HALF = 2.5;        // 200 MHz
    localparam real         SKEW = 0.4;        // per-domain delay step

    logic [NSEG-1:0] shift_clk = '0;
    logic            rst_n = 1'b0;
    logic            scan_en = 1'b1;
    logic            burnin_en = 1'b0;
    logic [NCH-1:0]  scan_in = '0;
    logic [TOT-1:0]  func_d = '0;
    logic [TOT-1:0]  func_q;
    logic [NCH-1:0]  scan_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [TOT-1:0] cur = '0;
    logic [TOT-1:0] prev = '0;

    xdom_scan_top dut (
        .shift_clk(shift_clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .burnin_en(burnin_en),
        .scan_in  (scan_in),
        .func_d   (func_d),
        .func_q   (func_q),
        .scan_out (scan_out)
    );

    // Skewed domain clocks: domain s lags domain 0 by s*SKEW.
    initial begin
        logic v;
        v = 1'b0;
        forever begin
            #(HALF - SKEW*(NSEG-1));
            v = ~v;
            for (int s = 0; s < NSEG; s++) begin
                shift_clk[s] = v;
                if (s < NSEG-1) #(SKEW);
            end
        end
    end

    function automatic bit flop_neg(input int i);
        int acc = 0;
        for (int s = 0; s < NSEG; s++) begin
            int len = int'(LENS[s*4 +: 4]);
            if (i < acc + len) return NEGS[s];
            acc += len;
        end
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: sample at reference rise + 1.5 ns, return at + 4.0 ns.
    task automatic step();
        logic [TOT-1:0] nxt;
        logic [TOT-1:0] expq;
        @(posedge shift_clk[0]);
        #1.5;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < CF; i++) begin
                int g = c*CF + i;
                if (scan_en) begin
                    if (i == 0) nxt[g] = (c > 0 && burnin_en) ? cur[g-1] : scan_in[c];
                    else        nxt[g] = cur[g-1];
                end else begin
                    nxt[g] = func_d[g];
                end
            end
        end
        prev = cur;
        cur  = nxt;
        for (int g = 0; g < TOT; g++) expq[g] = flop_neg(g % CF) ? prev[g] : cur[g];
        chk(scan_en ? "R2 shift into functional flops" : "R8 functional capture",
            64'(func_q), 64'(expq));
        for (int c = 0; c < NCH; c++) begin
            chk(burnin_en ? "R9/R10 joined chain output"
                          : "R7 latency through lockups R3 R4 R5 R6 R11",
                64'(scan_out[c]), 64'(prev[c*CF+CF-1]));
        end
        #2.5;
    endtask

    function automatic logic [TOT-1:0] rnd_vec();
        return TOT'({$urandom(), $urandom()});
    endfunction

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge shift_clk[0]);
        #1.5;
        chk("R1 reset func_q", 64'(func_q), 64'(0));
        chk("R1 reset scan_out", 64'(scan_out), 64'(0));
        #2.5;
        rst_n = 1'b1;

        // Directed: single one walking through both independent chains.
        scan_in = '1;
        step();
        scan_in = '0;
        for (int k = 0; k < CF + 3; k++) step();

        // Random shift, chains independent.
        for (int k = 0; k < 40; k++) begin
            scan_in = NCH'($urandom());
            step();
        end

        // Random mix of shift and functional capture.
        for (int k = 0; k < 40; k++) begin
            scan_en = ($urandom() % 4) != 0;
            func_d  = rnd_vec();
            scan_in = NCH'($urandom());
            step();
        end

        // Directed: all-ones capture, then shift zeros out.
        scan_en = 1'b0;
        func_d  = '1;
        step();
        scan_en = 1'b1;
        scan_in = '0;
        for (int k = 0; k < CF + 2; k++) step();

        // Burn-in: joined chain, scan_in[1] toggles with no effect.
        burnin_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            scan_in = NCH'($urandom());
            step();
        end

        // Mixed modes.
        for (int k = 0; k < 60; k++) begin
            burnin_en = $urandom() % 2;
            scan_en   = ($urandom() % 5) != 0;
            func_d    = rnd_vec();
            scan_in   = NCH'($urandom());
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000.0 * 2.0 * HALF);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule